// File: doc/BRIEF.md
# Striped Parity Array Datapath

This block sits between a logical byte stream and a group of four disk lanes that move in lockstep: three lanes hold data and the fourth always holds parity. In write mode, incoming record bytes are dealt out in rotation to data lanes 0, 1 and 2. Once a group of three is complete, or the record ends early, the block issues one stripe on all four lanes in the same beat. The parity byte is the XOR of the three data bytes, so a stripe whose four bytes XOR to zero is consistent.

In read mode a stripe enters from the four lanes. The lane named by the failed-lane index is discarded and rebuilt from the other three. The repaired stripe is placed on the lane outputs, and its three data bytes are replayed as a serial byte stream in the original record order. In check mode a stripe enters and a single flag reports whether its four bytes XOR to a nonzero value. A fourth mode code keeps every path quiet.

Top module: `stripe_raid`

## Requirements
- R1: While reset is asserted and on the first edge after it, `lane_valid` is 0, `out_valid` is 0, `chk_valid` is 0 and `chk_err` is 0.
- R2: In write mode (`mode`=0), byte n of a record goes to data lane n mod 3. Lane k occupies `lane_data` bits 8k+7:8k. After the third byte of a group is accepted, the stripe shows on the next cycle with `lane_valid`=4'b1111 for that one cycle.
- R3: Every stripe issued in write mode carries, on lane 3, the XOR of lanes 0, 1 and 2.
- R4: If a byte with `in_last`=1 completes a group early, the missing data positions are filled with zero and the stripe issues on the next cycle. The next byte accepted then starts a new group at lane 0. Leaving write mode also discards any partial group.
- R5: In read mode (`mode`=1), a stripe with `st_valid`=1 is output on the next cycle on all four lanes. The byte on lane `fail_lane` is ignored and replaced by the XOR of the other three lanes. Any lane 0 to 3 may be the failed one, including parity.
- R6: After a read stripe is accepted on an edge, `out_valid` is 1 for the next three cycles. `out_byte` carries the repaired data lanes 0, 1 and 2 in that order.
- R7: In check mode (`mode`=2), a stripe with `st_valid`=1 sets `chk_valid` for one cycle on the next cycle. `chk_err`=1 exactly when the XOR of the four lane bytes is nonzero. `chk_err` is 0 whenever `chk_valid` is 0.
- R8: In mode 3, and for whichever of the stripe input or byte input the current mode does not use, inputs have no effect: no lane, stream or check output is produced.
- R9: The four lane strobes are always all set or all clear, and every stripe on the lanes XORs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 write, 1 read, 2 check, 3 idle |
| fail_lane | input | 2 | Index of the lane to rebuild in read mode |
| in_valid | input | 1 | Record byte present (write mode) |
| in_byte | input | 8 | Record byte |
| in_last | input | 1 | Marks the final byte of a record |
| st_valid | input | 1 | Stripe present on `st_lanes` (read and check modes) |
| st_lanes | input | 32 | Incoming stripe, lane k in bits 8k+7:8k |
| lane_valid | output | 4 | Per-lane strobes, lockstep |
| lane_data | output | 32 | Outgoing stripe, lane k in bits 8k+7:8k |
| out_valid | output | 1 | Rebuilt record byte present |
| out_byte | output | 8 | Rebuilt record byte |
| chk_valid | output | 1 | Check result present |
| chk_err | output | 1 | Stripe failed the parity check |

## Verification
The properties assume that read stripes arrive no more often than once every three cycles, so a replay is never cut short by the next load. They also assume that `mode` holds steady for the length of any record that is being written. The stimulus spaces every read stripe at least three cycles apart, with some exactly three apart to test back-to-back replay. It changes mode only between records or after a quiet gap, and it corrupts the failed lane on purpose so that ignoring it is visible at the outputs.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_READ  = 2'd1,
    MODE_CHECK = 2'd2,
    MODE_IDLE  = 2'd3
  } stripe_mode_e;

  localparam int unsigned DEF_BYTE_W     = 8;
  localparam int unsigned DEF_DATA_LANES = 3;
endpackage

// File: rtl/stripe_xor_fold.sv
module stripe_xor_fold #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N      = 3
) (
  input  logic [N*BYTE_W-1:0] lanes,
  output logic [BYTE_W-1:0]   folded
);
  always_comb begin
    folded = '0;
    for (int i = 0; i < int'(N); i++) begin
      folded = folded ^ lanes[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/stripe_gather.sv
module stripe_gather #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned DATA_LANES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         take,
  input  logic                         flush,
  input  logic [BYTE_W-1:0]            in_byte,
  input  logic                         in_last,
  output logic                         fire,
  output logic [DATA_LANES*BYTE_W-1:0] data
);
  localparam int unsigned POS_W  = $clog2(DATA_LANES);
  localparam int unsigned HOLD_N = DATA_LANES - 1;
  localparam logic [POS_W-1:0] POS_END = POS_W'(DATA_LANES - 1);

  logic [POS_W-1:0]         pos_q, pos_d;
  logic [HOLD_N*BYTE_W-1:0] hold_q, hold_d;

  assign fire = take && ((pos_q == POS_END) || in_last);

  // Assemble the outgoing stripe: earlier bytes from holding, current byte at pos, zero beyond.
  for (genvar k = 0; k < int'(DATA_LANES); k++) begin : g_lane
    if (k < int'(HOLD_N)) begin : g_held
      always_comb begin
        if (pos_q > POS_W'(k))
          data[k*BYTE_W +: BYTE_W] = hold_q[k*BYTE_W +: BYTE_W];
        else if (pos_q == POS_W'(k))
          data[k*BYTE_W +: BYTE_W] = in_byte;
        else
          data[k*BYTE_W +: BYTE_W] = '0;
      end
      always_comb begin
        hold_d[k*BYTE_W +: BYTE_W] = hold_q[k*BYTE_W +: BYTE_W];
        if (take && pos_q == POS_W'(k))
          hold_d[k*BYTE_W +: BYTE_W] = in_byte;
      end
    end else begin : g_tail
      always_comb begin
        if (pos_q == POS_W'(k))
          data[k*BYTE_W +: BYTE_W] = in_byte;
        else
          data[k*BYTE_W +: BYTE_W] = '0;
      end
    end
  end

  always_comb begin
    pos_d = pos_q;
    if (flush)
      pos_d = '0;
    else if (fire)
      pos_d = '0;
    else if (take)
      pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hold_q <= '0;
    end else begin
      pos_q <= pos_d;
      if (take) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/stripe_repair.sv
module stripe_repair #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [LANES*BYTE_W-1:0] lanes_in,
  input  logic [IDX_W-1:0]        lost,
  output logic [LANES*BYTE_W-1:0] lanes_out,
  output logic [BYTE_W-1:0]       syndrome
);
  stripe_xor_fold #(.BYTE_W(BYTE_W), .N(LANES)) u_fold (
    .lanes  (lanes_in),
    .folded (syndrome)
  );

  // syndrome ^ own byte equals the XOR of every other lane.
  for (genvar k = 0; k < int'(LANES); k++) begin : g_fix
    assign lanes_out[k*BYTE_W +: BYTE_W] = (lost == IDX_W'(k))
      ? (syndrome ^ lanes_in[k*BYTE_W +: BYTE_W])
      : lanes_in[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/stripe_serial.sv
module stripe_serial #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned DATA_LANES = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [DATA_LANES*BYTE_W-1:0] data,
  output logic                         out_valid,
  output logic [BYTE_W-1:0]            out_byte
);
  localparam int unsigned CNT_W = $clog2(DATA_LANES);
  localparam int unsigned BUF_W = DATA_LANES * BYTE_W;

  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              step;

  assign step = load || (left_q != '0);

  always_comb begin
    buf_d  = buf_q;
    left_d = left_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (load) begin
      byte_d = data[BYTE_W-1:0];
      buf_d  = data >> BYTE_W;
      left_d = CNT_W'(DATA_LANES - 1);
      vld_d  = 1'b1;
    end else if (left_q != '0) begin
      byte_d = buf_q[BYTE_W-1:0];
      buf_d  = buf_q >> BYTE_W;
      left_d = left_q - 1'b1;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (step) begin
        buf_q  <= buf_d;
        left_q <= left_d;
        byte_q <= byte_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_byte  = byte_q;
endmodule

// File: rtl/stripe_raid.sv
module stripe_raid
  import stripe_pkg::*;
#(
  parameter int unsigned BYTE_W     = DEF_BYTE_W,
  parameter int unsigned DATA_LANES = DEF_DATA_LANES,
  localparam int unsigned LANES     = DATA_LANES + 1,
  localparam int unsigned IDX_W     = $clog2(LANES),
  localparam int unsigned DW        = DATA_LANES * BYTE_W,
  localparam int unsigned SW        = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [IDX_W-1:0]  fail_lane,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_last,
  input  logic              st_valid,
  input  logic [SW-1:0]     st_lanes,
  output logic [LANES-1:0]  lane_valid,
  output logic [SW-1:0]     lane_data,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              chk_valid,
  output logic              chk_err
);
  stripe_mode_e mode_e;
  assign mode_e = stripe_mode_e'(mode);

  logic wr_take, wr_fire, rd_take, ck_take;
  logic [DW-1:0]     wr_data;
  logic [BYTE_W-1:0] wr_par;
  logic [SW-1:0]     rd_fixed;
  logic [BYTE_W-1:0] rd_syn;

  assign wr_take = (mode_e == MODE_WRITE) && in_valid;
  assign rd_take = (mode_e == MODE_READ)  && st_valid;
  assign ck_take = (mode_e == MODE_CHECK) && st_valid;

  stripe_gather #(.BYTE_W(BYTE_W), .DATA_LANES(DATA_LANES)) u_gather (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (wr_take),
    .flush   (mode_e != MODE_WRITE),
    .in_byte (in_byte),
    .in_last (in_last),
    .fire    (wr_fire),
    .data    (wr_data)
  );

  stripe_xor_fold #(.BYTE_W(BYTE_W), .N(DATA_LANES)) u_par (
    .lanes  (wr_data),
    .folded (wr_par)
  );

  stripe_repair #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_repair (
    .lanes_in  (st_lanes),
    .lost      (fail_lane),
    .lanes_out (rd_fixed),
    .syndrome  (rd_syn)
  );

  stripe_serial #(.BYTE_W(BYTE_W), .DATA_LANES(DATA_LANES)) u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_take),
    .data      (rd_fixed[DW-1:0]),
    .out_valid (out_valid),
    .out_byte  (out_byte)
  );

  logic             lv_q, lv_d;
  logic [SW-1:0]    ld_q, ld_d;
  logic             ld_en;
  logic             cv_q, cv_d, ce_q, ce_d;

  always_comb begin
    ld_en = wr_fire || rd_take;
    lv_d  = ld_en;
    ld_d  = ld_q;
    if (wr_fire)
      ld_d = {wr_par, wr_data};
    else if (rd_take)
      ld_d = rd_fixed;
    cv_d = ck_take;
    ce_d = ck_take && (rd_syn != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv_q <= 1'b0;
      ld_q <= '0;
      cv_q <= 1'b0;
      ce_q <= 1'b0;
    end else begin
      lv_q <= lv_d;
      cv_q <= cv_d;
      ce_q <= ce_d;
      if (ld_en) ld_q <= ld_d;
    end
  end

  assign lane_valid = {LANES{lv_q}};
  assign lane_data  = ld_q;
  assign chk_valid  = cv_q;
  assign chk_err    = ce_q;
endmodule

// File: rtl/stripe_raid_chk.sv
module stripe_raid_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              st_valid,
  input logic [LANES-1:0]  lane_valid,
  input logic [LANES*BYTE_W-1:0] lane_data,
  input logic              out_valid,
  input logic              chk_valid,
  input logic              chk_err
);
  function automatic logic [BYTE_W-1:0] fold(input logic [LANES*BYTE_W-1:0] v);
    logic [BYTE_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < int'(LANES); i++) acc = acc ^ v[i*BYTE_W +: BYTE_W];
    return acc;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (lane_valid == '0 && !out_valid && !chk_valid && !chk_err);
    end
  end

  a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid == '0) || (lane_valid == {LANES{1'b1}}));

  a_r3_stripe_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0) |-> (fold(lane_data) == '0));

  a_r7_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> chk_valid);

  a_r7_check_source: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |-> $past(st_valid && mode == 2'd2));

  a_r6_stream_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(st_valid && mode == 2'd1));

  a_r6_three_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |=> out_valid);

  a_r8_lanes_source: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_valid != '0) |-> $past(mode == 2'd0 || mode == 2'd1));
endmodule

bind stripe_raid stripe_raid_chk #(.BYTE_W(BYTE_W), .LANES(LANES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .st_valid   (st_valid),
  .lane_valid (lane_valid),
  .lane_data  (lane_data),
  .out_valid  (out_valid),
  .chk_valid  (chk_valid),
  .chk_err    (chk_err)
);

// File: tb/stripe_raid_bench.sv
module stripe_raid_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk, rst_n;
  logic [1:0] mode, fail_lane;
  logic in_valid, in_last, st_valid;
  logic [7:0] in_byte;
  logic [31:0] st_lanes;
  logic [3:0] lane_valid;
  logic [31:0] lane_data;
  logic out_valid, chk_valid, chk_err;
  logic [7:0] out_byte;

  stripe_raid u_stripe_raid (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fail_lane(fail_lane),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .st_valid(st_valid), .st_lanes(st_lanes),
    .lane_valid(lane_valid), .lane_data(lane_data),
    .out_valid(out_valid), .out_byte(out_byte),
    .chk_valid(chk_valid), .chk_err(chk_err)
  );

  int errors = 0, checks = 0, cycles = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R2";

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_val(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] wq[$];
  logic [7:0] oq[$];
  logic [7:0] m_l[4];
  bit m_lv, m_ov, m_cv, m_ce;
  logic [7:0] m_ob;

  always @(posedge clk) begin
    if (!rst_n) begin
      wq.delete(); oq.delete();
      m_lv = 0; m_ov = 0; m_cv = 0; m_ce = 0;
    end else begin
      logic [7:0] x;
      m_lv = 0; m_cv = 0; m_ce = 0;
      if (mode != 2'd0) wq.delete();
      else if (in_valid) begin
        wq.push_back(in_byte);
        if (wq.size() == 3 || in_last) begin
          while (wq.size() < 3) wq.push_back(8'h00);
          for (int k = 0; k < 3; k++) m_l[k] = wq[k];
          m_l[3] = wq[0] ^ wq[1] ^ wq[2];
          m_lv = 1;
          wq.delete();
        end
      end
      x = st_lanes[7:0] ^ st_lanes[15:8] ^ st_lanes[23:16] ^ st_lanes[31:24];
      if (mode == 2'd1 && st_valid) begin
        for (int k = 0; k < 4; k++)
          m_l[k] = (k == int'(fail_lane)) ? (x ^ st_lanes[k*8 +: 8]) : st_lanes[k*8 +: 8];
        m_lv = 1;
        for (int k = 0; k < 3; k++) oq.push_back(m_l[k]);
      end
      if (mode == 2'd2 && st_valid) begin
        m_cv = 1;
        m_ce = (x != 8'h00);
      end
      if (oq.size() > 0) begin m_ov = 1; m_ob = oq.pop_front(); end
      else m_ov = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check_val("R9", lane_valid, m_lv ? 4'hF : 4'h0);
      if (m_lv) check_val(cur_req, lane_data, {m_l[3], m_l[2], m_l[1], m_l[0]});
      check_val("R6", out_valid, m_ov);
      if (m_ov) check_val("R6", out_byte, m_ob);
      check_val("R7", chk_valid, m_cv);
      check_val("R7", chk_err, m_ce);
    end
  end

  task automatic put_wr(logic [7:0] b, bit last);
    @(negedge clk);
    mode = 2'd0; in_valid = 1; in_byte = b; in_last = last; st_valid = 0;
  endtask

  task automatic put_st(logic [1:0] md, logic [1:0] fl, logic [31:0] s);
    @(negedge clk);
    mode = md; fail_lane = fl; st_valid = 1; st_lanes = s; in_valid = 0; in_last = 0;
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_last = 0; st_valid = 0;
    end
  endtask

  function automatic logic [31:0] mk(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    return {a ^ b ^ c, c, b, a};
  endfunction

  initial begin
    rst_n = 0; mode = 2'd3; fail_lane = 0; in_valid = 0; in_byte = 0; in_last = 0;
    st_valid = 0; st_lanes = 0;
    repeat (3) @(negedge clk);
    check_val("R1", {lane_valid, out_valid, chk_valid, chk_err}, 0);
    rst_n = 1;
    @(negedge clk);
    check_val("R1", {lane_valid, out_valid, chk_valid, chk_err}, 0);
    cmp_on = 1;

    // R2 / R3: full groups
    cur_req = "R2";
    put_wr(8'h11, 0); put_wr(8'h22, 0); put_wr(8'h33, 0);
    put_wr(8'h44, 0);
    check_val("R2", lane_data, 32'h00332211);
    put_wr(8'h55, 0); put_wr(8'h66, 1);
    quiet(1);
    check_val("R3", lane_data, 32'h77665544);

    // R4: short tails
    cur_req = "R4";
    put_wr(8'hA1, 0); put_wr(8'hB2, 0); put_wr(8'hC3, 0); put_wr(8'hD4, 1);
    quiet(1);
    check_val("R4", lane_data, 32'hD40000D4);
    put_wr(8'h5A, 0); put_wr(8'hC3, 1);
    quiet(1);
    check_val("R4", lane_data, {8'h5A ^ 8'hC3, 8'h00, 8'hC3, 8'h5A});
    // partial group abandoned by mode change
    put_wr(8'h99, 0); quiet(1);
    @(negedge clk); mode = 2'd3; quiet(1);
    put_wr(8'h01, 0); put_wr(8'h02, 0); put_wr(8'h03, 0);
    quiet(1);
    check_val("R4", lane_data, 32'h00030201);

    // R3 random writes with gaps
    cur_req = "R3";
    for (int r = 0; r < 40; r++) begin
      put_wr(8'($urandom), ($urandom % 7) == 0);
      if ($urandom % 3 == 0) begin @(negedge clk); in_valid = 0; in_last = 0; end
    end
    quiet(2);

    // R5 / R6: degraded read, each failed lane, corrupted input
    cur_req = "R5";
    put_st(2'd1, 2'd1, {8'h70, 8'h56, 8'hFF, 8'h12});
    quiet(1);
    check_val("R5", lane_data, 32'h70563412);
    check_val("R6", out_byte, 8'h12);
    quiet(1);
    check_val("R6", out_byte, 8'h34);
    quiet(1);
    check_val("R6", out_byte, 8'h56);
    quiet(1);
    check_val("R6", out_valid, 0);
    for (int f = 0; f < 4; f++) begin
      logic [31:0] s;
      s = mk(8'($urandom), 8'($urandom), 8'($urandom));
      s[f*8 +: 8] = ~s[f*8 +: 8];
      put_st(2'd1, 2'(f), s);
      quiet(2);
    end
    for (int r = 0; r < 30; r++) begin
      put_st(2'd1, 2'($urandom), $urandom);
      quiet(2 + ($urandom % 2));
    end
    quiet(3);

    // R7: check mode
    cur_req = "R7";
    put_st(2'd2, 2'd0, mk(8'h10, 8'h20, 8'h40));
    quiet(1);
    check_val("R7", {chk_valid, chk_err}, 2'b10);
    put_st(2'd2, 2'd0, mk(8'h10, 8'h20, 8'h40) ^ 32'h00000100);
    quiet(1);
    check_val("R7", {chk_valid, chk_err}, 2'b11);
    check_val("R7", lane_valid, 0);
    for (int r = 0; r < 20; r++) begin
      put_st(2'd2, 2'd0, ($urandom % 2) ? mk(8'($urandom), 8'($urandom), 8'($urandom)) : $urandom);
    end
    quiet(2);

    // R8: unused inputs ignored
    cur_req = "R8";
    @(negedge clk); mode = 2'd3; in_valid = 1; in_byte = 8'hEE; in_last = 1;
    st_valid = 1; st_lanes = 32'h12345678;
    @(negedge clk);
    check_val("R8", {lane_valid, out_valid, chk_valid}, 0);
    mode = 2'd0; in_valid = 0; in_last = 0; st_valid = 1;
    @(negedge clk);
    check_val("R8", {lane_valid, out_valid, chk_valid}, 0);
    mode = 2'd1; st_valid = 0; in_valid = 1; in_last = 1;
    @(negedge clk);
    check_val("R8", {lane_valid, out_valid, chk_valid}, 0);
    in_valid = 0; in_last = 0;
    quiet(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule